// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, judging only by its 48-bit destination address. The six address bytes arrive one at a time on a byte stream that a one-cycle frame-start pulse opens. While the bytes arrive, the block stores the address and runs a CRC-32 over it. When the sixth byte has been taken, it gives a verdict of accept or reject. The verdict is built from a station address, a small set of extra unicast entries that each carry an enable bit, a 64-bin multicast hash table and three mode bits.

The control is a four-state machine:
- `ST_IDLE` is the state after reset. It waits for a frame start.
- `ST_CAPTURE` takes address bytes and counts them.
- `ST_DECIDE` lasts one cycle. The verdict is computed and shown.
- `ST_HOLD` keeps the latched verdict until the next frame start.

The transitions are:
- start: any state goes to `ST_CAPTURE` on a frame-start pulse.
- last-byte: `ST_CAPTURE` goes to `ST_DECIDE` when the sixth byte is taken.
- latch: `ST_DECIDE` goes to `ST_HOLD` unconditionally.
- In all other cases the state stays where it is.

Top module: `rdf_dest_filter`

## Requirements
- R1: While promiscuous mode is set, every frame's verdict is accept, whatever its destination.
- R2: Address bytes are numbered 0 to 5 in arrival order. A register pair holds byte 0 in bits 7:0 of the low word, on up to byte 3 in bits 31:24, and holds bytes 4 and 5 in bits 7:0 and 15:8 of the high word. A unicast destination equal to the station pair is accepted.
- R3: Each extra entry has a 17-bit high field. Bits 15:0 hold address bytes 4 and 5, and bit 16 is the enable. A unicast destination that equals an extra entry is accepted when that entry's enable is one. The entry has no effect when its enable is zero.
- R4: The hash is a CRC-32 over the six address bytes in arrival order. It uses polynomial 0x04C11DB7 and preset 0xFFFFFFFF, takes each byte least significant bit first, and inverts the result at the end.
- R5: The hash index k is bits 31:26 of the inverted CRC. Index k selects bit k mod 32 of table word k div 32. Word 0 is the low table port and word 1 is the high table port.
- R6: A destination is multicast when bit 0 of byte 0 is one. While pass-all-multicast is set, every multicast destination is accepted without consulting the table.
- R7: While hash-multicast is set and pass-all-multicast is clear, a multicast destination is accepted exactly when its table bit is one.
- R8: Outside promiscuous mode, a multicast destination is rejected when neither multicast mode is set. A unicast destination that matches no active entry is also rejected.
- R9: The verdict-valid output rises in the cycle after the sixth byte is taken. It then holds a stable verdict until the next frame start, and it is low in the cycle after any frame start.
- R10: A byte that is valid in the same cycle as the frame-start pulse is taken as byte 0 of the new address. A frame start in the middle of a capture discards the bytes taken so far.
- R11: After reset, the verdict-valid and accept outputs are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | One-cycle pulse that opens a new address capture |
| byte_valid | input | 1 | byte_data carries an address byte |
| byte_data | input | 8 | Address byte, byte 0 first |
| station_lo | input | 32 | Station address bytes 0 to 3 |
| station_hi | input | 16 | Station address bytes 4 and 5 |
| extra_lo | input | NUM_EXTRA*32 | Extra entries, bytes 0 to 3, entry e at bits e*32 and up |
| extra_hi | input | NUM_EXTRA*17 | Extra entries, bytes 4 and 5 plus the enable bit at bit 16, entry e at bits e*17 and up |
| hash_lo | input | 32 | Hash table word 0 |
| hash_hi | input | 32 | Hash table word 1 |
| promisc | input | 1 | Accept all frames |
| pass_all_mc | input | 1 | Accept all multicast frames |
| hash_mc | input | 1 | Filter multicast frames through the hash table |
| verdict_valid | output | 1 | Verdict is available |
| verdict_accept | output | 1 | Frame accepted, meaningful while verdict_valid is high |

## Verification
A frame-start pulse and a valid byte can fall in the same cycle. The restart of the CRC and the byte counter then meets the capture of byte 0. The bench provokes this with directed frames that place the first byte beside the pulse. It also restarts a frame halfway through its capture. In both cases it judges the verdict against a model computed only from the address sent after the pulse, and it checks that verdict-valid stays low until six fresh bytes have been taken.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;
    localparam int HASH_BITS  = 6;
    localparam int HI_W       = 17;   // 16 address bits plus enable
    localparam int EN_BIT     = 16;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_HOLD    = 2'd3
    } rdf_state_t;
endpackage

// File: rtl/rdf_crc_step.sv
module rdf_crc_step
    import rdf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] stage [0:8];

    assign stage[0] = crc_in;

    // One serial CRC step per data bit, least significant bit first
    generate
        for (genvar b = 0; b < 8; b++) begin : g_bit
            logic fb;
            assign fb = stage[b][CRC_W-1] ^ data_in[b];
            assign stage[b+1] = fb ? ({stage[b][CRC_W-2:0], 1'b0} ^ CRC_POLY)
                                   : {stage[b][CRC_W-2:0], 1'b0};
        end
    endgenerate

    assign crc_out = stage[8];
endmodule

// File: rtl/rdf_addr_match.sv
module rdf_addr_match
    import rdf_pkg::*;
#(
    parameter int NUM_EXTRA = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               station_lo,
    input  logic [15:0]               station_hi,
    input  logic [NUM_EXTRA*32-1:0]   extra_lo,
    input  logic [NUM_EXTRA*HI_W-1:0] extra_hi,
    output logic                      hit
);
    logic [NUM_EXTRA-1:0] entry_hit;
    logic                 station_hit;

    assign station_hit = (addr == {station_hi, station_lo});

    generate
        for (genvar e = 0; e < NUM_EXTRA; e++) begin : g_entry
            logic en;
            logic [ADDR_W-1:0] ref_addr;
            assign en        = extra_hi[e*HI_W + EN_BIT];
            assign ref_addr  = {extra_hi[e*HI_W +: 16], extra_lo[e*32 +: 32]};
            assign entry_hit[e] = en && (addr == ref_addr);
        end
    endgenerate

    assign hit = station_hit || (|entry_hit);
endmodule

// File: rtl/rdf_hash_lookup.sv
module rdf_hash_lookup
    import rdf_pkg::*;
(
    input  logic [HASH_BITS-1:0] crc_top,   // raw (not yet inverted) CRC bits 31:26
    input  logic [31:0]          tbl_lo,
    input  logic [31:0]          tbl_hi,
    output logic                 bin_set
);
    localparam int BINS = 1 << HASH_BITS;

    logic [HASH_BITS-1:0] idx;
    logic [BINS-1:0]      table_bits;

    assign idx        = ~crc_top;
    assign table_bits = {tbl_hi, tbl_lo};
    assign bin_set    = table_bits[idx];
endmodule

// File: rtl/rdf_dest_filter.sv
module rdf_dest_filter
    import rdf_pkg::*;
#(
    parameter int NUM_EXTRA = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frm_start,
    input  logic                      byte_valid,
    input  logic [7:0]                byte_data,
    input  logic [31:0]               station_lo,
    input  logic [15:0]               station_hi,
    input  logic [NUM_EXTRA*32-1:0]   extra_lo,
    input  logic [NUM_EXTRA*HI_W-1:0] extra_hi,
    input  logic [31:0]               hash_lo,
    input  logic [31:0]               hash_hi,
    input  logic                      promisc,
    input  logic                      pass_all_mc,
    input  logic                      hash_mc,
    output logic                      verdict_valid,
    output logic                      verdict_accept
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    rdf_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q, crc_base, crc_next;
    logic [CNT_W-1:0]  cnt_q, cnt_base;
    logic              held_q;
    logic              take;
    logic              uc_hit, mc_bin, is_group, decide_now;

    // A byte is taken while capturing, or together with a start pulse
    assign take     = byte_valid && (frm_start || (state_q == ST_CAPTURE));
    assign crc_base = frm_start ? CRC_PRESET : crc_q;
    assign cnt_base = frm_start ? '0 : cnt_q;

    rdf_crc_step u_crc (
        .crc_in  (crc_base),
        .data_in (byte_data),
        .crc_out (crc_next)
    );

    rdf_addr_match #(.NUM_EXTRA(NUM_EXTRA)) u_match (
        .addr       (addr_q),
        .station_lo (station_lo),
        .station_hi (station_hi),
        .extra_lo   (extra_lo),
        .extra_hi   (extra_hi),
        .hit        (uc_hit)
    );

    rdf_hash_lookup u_hash (
        .crc_top (crc_q[CRC_W-1 -: HASH_BITS]),
        .tbl_lo  (hash_lo),
        .tbl_hi  (hash_hi),
        .bin_set (mc_bin)
    );

    assign is_group = addr_q[0];

    always_comb begin
        if (promisc) begin
            decide_now = 1'b1;
        end else if (is_group) begin
            if (pass_all_mc)  decide_now = 1'b1;
            else if (hash_mc) decide_now = mc_bin;
            else              decide_now = 1'b0;
        end else begin
            decide_now = uc_hit;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_CAPTURE: if (byte_valid && (cnt_q == LAST_IDX)) state_d = ST_DECIDE;
            ST_DECIDE:  state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_HOLD;
        endcase
        if (frm_start) state_d = ST_CAPTURE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            crc_q  <= CRC_PRESET;
            cnt_q  <= '0;
            held_q <= 1'b0;
        end else begin
            if (take) begin
                addr_q <= {byte_data, addr_q[ADDR_W-1:8]};
                crc_q  <= crc_next;
                cnt_q  <= cnt_base + 1'b1;
            end else if (frm_start) begin
                crc_q  <= CRC_PRESET;
                cnt_q  <= '0;
            end
            if (state_q == ST_DECIDE) held_q <= decide_now;
        end
    end

    // Outputs
    always_comb begin
        verdict_valid  = 1'b0;
        verdict_accept = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CAPTURE: begin
            end
            ST_DECIDE: begin
                verdict_valid  = 1'b1;
                verdict_accept = decide_now;
            end
            ST_HOLD: begin
                verdict_valid  = 1'b1;
                verdict_accept = held_q;
            end
        endcase
    end
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_start,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       promisc,
    input logic       pass_all_mc,
    input logic       hash_mc,
    input logic       verdict_valid,
    input logic       verdict_accept
);
    // Independent byte count since the last start; 7 means no frame open
    logic [2:0] seen;
    logic       grp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 3'd7;
            grp  <= 1'b0;
        end else if (frm_start) begin
            seen <= byte_valid ? 3'd1 : 3'd0;
            if (byte_valid) grp <= byte_data[0];
        end else if (byte_valid && seen < 3'd6) begin
            if (seen == 3'd0) grp <= byte_data[0];
            seen <= seen + 3'd1;
        end
    end

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> !verdict_valid && !verdict_accept);

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !verdict_valid);

    assert_sixth_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !frm_start && seen == 3'd5) |=> verdict_valid);

    assert_no_early_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verdict_valid) |-> seen == 3'd6);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && $past(verdict_valid)) |-> $stable(verdict_accept));

    assert_promisc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(verdict_valid) && promisc) |-> verdict_accept);

    assert_pass_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(verdict_valid) && grp && pass_all_mc) |-> verdict_accept);

    assert_mcast_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(verdict_valid) && grp && !promisc && !pass_all_mc && !hash_mc)
            |-> !verdict_accept);
endmodule

bind rdf_dest_filter rdf_checker u_rdf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .frm_start      (frm_start),
    .byte_valid     (byte_valid),
    .byte_data      (byte_data),
    .promisc        (promisc),
    .pass_all_mc    (pass_all_mc),
    .hash_mc        (hash_mc),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept)
);

// File: tb/test_rdf_dest_filter.sv
module test_rdf_dest_filter;
    localparam int NX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_start = 1'b0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic [31:0] station_lo = '0;
    logic [15:0] station_hi = '0;
    logic [NX*32-1:0] extra_lo = '0;
    logic [NX*17-1:0] extra_hi = '0;
    logic [31:0] hash_lo = '0, hash_hi = '0;
    logic promisc = 1'b0, pass_all_mc = 1'b0, hash_mc = 1'b0;
    logic verdict_valid, verdict_accept;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    rdf_dest_filter #(.NUM_EXTRA(NX)) i_rdf_dest_filter (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .station_lo(station_lo), .station_hi(station_hi),
        .extra_lo(extra_lo), .extra_hi(extra_hi), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .promisc(promisc), .pass_all_mc(pass_all_mc), .hash_mc(hash_mc),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4/R5: hash bin per the stated CRC rules
    function automatic bit model_bin(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [63:0] tbl = {hash_hi, hash_lo};
        logic [5:0]  k;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 8; j++)
                if (c[31] ^ a[8*i+j]) c = (c << 1) ^ 32'h04C1_1DB7;
                else                  c = c << 1;
        c = ~c;
        k = c[31:26];
        return tbl[k];
    endfunction

    function automatic bit model_accept(input logic [47:0] a);
        bit hit;
        if (promisc) return 1'b1;
        if (a[0]) begin
            if (pass_all_mc) return 1'b1;
            if (hash_mc)     return model_bin(a);
            return 1'b0;
        end
        hit = (a == {station_hi, station_lo});
        for (int e = 0; e < NX; e++)
            if (extra_hi[e*17+16] && a == {extra_hi[e*17 +: 16], extra_lo[e*32 +: 32]})
                hit = 1'b1;
        return hit;
    endfunction

    // Sends one address; checks valid low on the last byte and the verdict after it
    task automatic send(input logic [47:0] a, input bit start_byte, input int gap_max,
                        input string req);
        int first;
        @(negedge clk);
        frm_start = 1'b1;
        byte_valid = start_byte;
        byte_data = a[7:0];
        first = start_byte ? 1 : 0;
        for (int i = first; i < 6; i++) begin
            @(negedge clk);
            frm_start = 1'b0;
            byte_valid = 1'b0;
            repeat ($urandom_range(0, gap_max)) @(negedge clk);
            byte_valid = 1'b1;
            byte_data = a[8*i +: 8];
        end
        check({31'd0, verdict_valid}, 32'd0, {req, " R9 early"});
        @(negedge clk);
        byte_valid = 1'b0;
        check({31'd0, verdict_valid}, 32'd1, {req, " R9 valid"});
        check({31'd0, verdict_accept}, {31'd0, model_accept(a)}, req);
    endtask

    task automatic random_cfg();
        station_lo = $urandom(); station_hi = 16'($urandom());
        station_lo[0] = 1'b0;
        for (int e = 0; e < NX; e++) begin
            extra_lo[e*32 +: 32] = $urandom() & 32'hFFFF_FFFE;
            extra_hi[e*17 +: 17] = 17'($urandom());
        end
        hash_lo = $urandom(); hash_hi = $urandom();
        promisc     = ($urandom_range(0, 7) == 0);
        pass_all_mc = ($urandom_range(0, 3) == 0);
        hash_mc     = ($urandom_range(0, 1) == 0);
    endtask

    function automatic logic [47:0] pick_addr();
        int s = $urandom_range(0, 7);
        logic [47:0] r = {16'($urandom()), 32'($urandom())};
        if (s == 0) return {station_hi, station_lo};
        if (s <= NX) return {extra_hi[(s-1)*17 +: 16], extra_lo[(s-1)*32 +: 32]};
        if (s == 4) return 48'hFFFF_FFFF_FFFF;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] a;
        bit held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check({30'd0, verdict_valid, verdict_accept}, 32'd0, "R11 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check({30'd0, verdict_valid, verdict_accept}, 32'd0, "R11 idle after reset");

        // R2: station match, byte order
        station_lo = 32'h4433_2210; station_hi = 16'h6655;
        send(48'h6655_4433_2210, 1'b0, 0, "R2 station hit");
        send(48'h6655_4433_2212, 1'b0, 1, "R8 unicast miss");

        // R3: extra entry 1 with enable clear, then set
        a = 48'hA1B2_C3D4_E5F6;
        extra_lo[32 +: 32] = a[31:0];
        extra_hi[17 +: 17] = {1'b0, a[47:32]};
        send(a, 1'b0, 0, "R3 disabled entry");
        check({31'd0, verdict_accept}, 32'd0, "R3 disabled rejects");
        extra_hi[17+16] = 1'b1;
        send(a, 1'b0, 0, "R3 enabled entry");
        check({31'd0, verdict_accept}, 32'd1, "R3 enabled accepts");

        // R6/R7/R8 on a broadcast address
        hash_lo = 32'h0; hash_hi = 32'h0; hash_mc = 1'b1;
        send(48'hFFFF_FFFF_FFFF, 1'b0, 0, "R7 empty table");
        hash_lo = 32'hFFFF_FFFF; hash_hi = 32'hFFFF_FFFF;
        send(48'hFFFF_FFFF_FFFF, 1'b0, 0, "R7 full table");
        hash_mc = 1'b0;
        send(48'h0000_0000_0001, 1'b0, 0, "R8 mcast no mode");
        pass_all_mc = 1'b1; hash_lo = '0; hash_hi = '0;
        send(48'h0000_0000_0001, 1'b0, 0, "R6 pass all");
        pass_all_mc = 1'b0;
        promisc = 1'b1;
        send(48'h1234_5678_9ABC, 1'b1, 0, "R1 promisc");
        promisc = 1'b0;

        // R10: first byte beside the start pulse
        send(48'h6655_4433_2210, 1'b1, 2, "R10 byte with start");

        // R10: restart in the middle of a capture
        @(negedge clk);
        frm_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h10;
        for (int i = 1; i < 3; i++) begin
            @(negedge clk); frm_start = 1'b0; byte_data = 8'h99;
        end
        send(48'h0000_0000_0012, 1'b0, 0, "R10 restart");

        // R9: verdict held while configuration moves
        send(48'h6655_4433_2210, 1'b0, 0, "R9 hold setup");
        held = verdict_accept;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            promisc = ~promisc;
            station_lo = $urandom();
        end
        @(negedge clk);
        check({30'd0, verdict_valid, verdict_accept}, {30'd0, 1'b1, held}, "R9 held verdict");
        promisc = 1'b0;
        @(negedge clk);
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        check({31'd0, verdict_valid}, 32'd0, "R9 start clears");

        // Random traffic, checks R1..R8 through the model
        random_cfg();
        for (int f = 0; f < 300; f++) begin
            if ($urandom_range(0, 7) == 0) random_cfg();
            send(pick_addr(), bit'($urandom_range(0, 1)), 3, "R4 R5 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule